// File: doc/BRIEF.md
# Packed Float/Word Saturating Converter

This block converts a 128-bit vector of four 32-bit lanes between IEEE-754 single precision and 32-bit integers. A 2-bit operation code picks one of four conversions. All four lanes go through the same conversion at the same time. In the float-to-integer direction each lane is truncated toward zero and then clamped to the range of the destination. In the integer-to-float direction each lane is rounded to the nearest float, with ties going to even.

Inputs are taken through a valid/ready handshake. Each result goes into a single output register and stays there until the consumer takes it. A four-bit flag vector travels with each result. It marks the lanes whose float-to-integer result was clamped or came from a NaN.

Top module: `vec_fpint_cvt`

## Requirements
- R1: All four lanes (lane i in bits 32*i+31 down to 32*i) are converted independently with the operation given by `in_op`.
- R2: Float-to-integer drops the fractional part (rounds toward zero) before the range check. Any input of magnitude below 1, denormals included, gives 0.
- R3: Signed float-to-integer: a truncated value below -2^31 gives 0x80000000, and a value above 2^31-1 gives 0x7FFFFFFF. -2^31 itself converts exactly.
- R4: Unsigned float-to-integer: a truncated value below 0 gives 0x00000000, and a value above 2^32-1 gives 0xFFFFFFFF.
- R5: A NaN lane gives the destination minimum: 0x80000000 when signed, 0x00000000 when unsigned.
- R6: +Inf gives the destination maximum and -Inf gives the destination minimum.
- R7: Integer-to-float reads each lane as signed or unsigned and writes a single-precision value to the same lane. Inexact values round to nearest with ties to even, and zero gives +0.0.
- R8: Operation code: 2'b00 float to signed, 2'b01 float to unsigned, 2'b10 signed to float, 2'b11 unsigned to float.
- R9: A result is on `out_data` with `out_valid` high on the clock edge that accepts the input (`in_valid` and `in_ready` both high). `out_valid`, `out_data` and `out_sat` hold steady while `out_ready` is low, and `in_ready` is low during that time.
- R10: `out_sat[i]` is 1 when lane i of a float-to-integer result was clamped or came from a NaN. A negative input that truncates to zero is not counted as clamped. In integer-to-float modes all flags are 0.
- R11: While reset is high and after it, `out_valid`, `out_data` and `out_sat` are zero until the first accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_op | input | 2 | Conversion select |
| in_data | input | 128 | Four source lanes |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Four converted lanes |
| out_sat | output | 4 | Per-lane clamp/NaN flags |

## Verification
The bench aims at the values right at the clamp boundaries: -2^31, which must convert exactly in signed mode; 2^31, which must clamp in signed mode but not in unsigned mode; and the largest float below 2^32. A design with an off-by-one compare would flag or clamp these values wrongly. NaN, both infinities, denormals and small negative fractions are also applied; an ordering mistake there would send a NaN to the maximum or mark -0.5 as clamped. Integer-to-float vectors cover an exact tie and a tie plus one ulp, and carry rounding up into the next binade, which a truncating or round-half-up design would miss. A backpressure sequence checks that a held result is neither overwritten nor dropped.

// File: rtl/vec_fpint_cvt_pkg.sv
package vec_fpint_cvt_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        OP_F2S = 2'b00,
        OP_F2U = 2'b01,
        OP_S2F = 2'b10,
        OP_U2F = 2'b11
    } cvt_op_e;

    typedef struct packed {
        logic              sat;
        logic [LANE_W-1:0] val;
    } lane_res_t;

    localparam logic [LANE_W-1:0] SMIN = 32'h8000_0000;
    localparam logic [LANE_W-1:0] SMAX = 32'h7FFF_FFFF;
    localparam logic [LANE_W-1:0] UMIN = 32'h0000_0000;
    localparam logic [LANE_W-1:0] UMAX = 32'hFFFF_FFFF;

    localparam logic [7:0] EXP_ALL1 = 8'hFF;
    localparam logic [7:0] EXP_ONE  = 8'd127;  // value 1.0
    localparam logic [7:0] EXP_INT  = 8'd150;  // ulp of mantissa == 1
    localparam logic [7:0] EXP_OVF  = 8'd159;  // magnitude >= 2^32

    // float -> integer, truncate then clamp
    function automatic lane_res_t float_to_int(input logic [LANE_W-1:0] x,
                                               input logic              uns);
        lane_res_t   r;
        logic        sgn;
        logic [7:0]  ex;
        logic [22:0] fr;
        logic [63:0] mag;
        logic [7:0]  sh;
        sgn = x[31];
        ex  = x[30:23];
        fr  = x[22:0];
        r   = '0;
        mag = {40'd0, 1'b1, fr};
        sh  = 8'd0;
        if (ex == EXP_ALL1 && fr != 23'd0) begin
            r.val = uns ? UMIN : SMIN;
            r.sat = 1'b1;
        end else if (ex == EXP_ALL1 || ex >= EXP_OVF) begin
            if (sgn) r.val = uns ? UMIN : SMIN;
            else     r.val = uns ? UMAX : SMAX;
            r.sat = 1'b1;
        end else if (ex < EXP_ONE) begin
            r.val = '0;
        end else begin
            if (ex >= EXP_INT) begin
                sh  = ex - EXP_INT;
                mag = mag << sh;
            end else begin
                sh  = EXP_INT - ex;
                mag = mag >> sh;
            end
            if (uns) begin
                if (sgn) begin
                    r.val = UMIN;
                    r.sat = 1'b1;
                end else begin
                    r.val = mag[31:0];
                end
            end else if (sgn) begin
                if (mag > 64'h0000_0000_8000_0000) begin
                    r.val = SMIN;
                    r.sat = 1'b1;
                end else begin
                    r.val = 32'd0 - mag[31:0];
                end
            end else if (mag > 64'h0000_0000_7FFF_FFFF) begin
                r.val = SMAX;
                r.sat = 1'b1;
            end else begin
                r.val = mag[31:0];
            end
        end
        return r;
    endfunction

    // integer -> float, round to nearest even
    function automatic logic [LANE_W-1:0] int_to_float(input logic [LANE_W-1:0] x,
                                                       input logic              uns);
        logic        sgn;
        logic [31:0] mag;
        logic [31:0] norm;
        logic [4:0]  lead;
        logic [24:0] sig;
        logic        rnd;
        logic [7:0]  ex;
        sgn  = ~uns & x[31];
        mag  = sgn ? (32'd0 - x) : x;
        lead = 5'd0;
        for (int i = 0; i < 32; i++) begin
            if (mag[i]) lead = 5'(i);
        end
        norm = mag << (5'd31 - lead);
        rnd  = norm[7] & ((|norm[6:0]) | norm[8]);
        sig  = {1'b0, norm[31:8]} + {24'd0, rnd};
        ex   = EXP_ONE + {3'd0, lead} + {7'd0, sig[24]};
        if (mag == 32'd0) return '0;
        return {sgn, ex, sig[22:0]};
    endfunction

endpackage

// File: rtl/cvt_lane.sv
module cvt_lane
    import vec_fpint_cvt_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [LANE_W-1:0] src,
    output logic [LANE_W-1:0] dst,
    output logic              sat
);
    lane_res_t res;

    always_comb begin
        res = '0;
        case (cvt_op_e'(op))
            OP_F2S: res = float_to_int(src, 1'b0);
            OP_F2U: res = float_to_int(src, 1'b1);
            OP_S2F: res.val = int_to_float(src, 1'b0);
            OP_U2F: res.val = int_to_float(src, 1'b1);
            default: res = '0;
        endcase
    end

    assign dst = res.val;
    assign sat = res.sat;
endmodule

// File: rtl/cvt_out_stage.sv
module cvt_out_stage #(
    parameter int DW = 128,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] d_data,
    input  logic [FW-1:0] d_flag,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] q_data,
    output logic [FW-1:0] q_flag
);
    logic take;

    assign in_ready = ~out_valid | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q_data    <= '0;
            q_flag    <= '0;
        end else begin
            if (take) begin
                q_data <= d_data;
                q_flag <= d_flag;
            end
            if (take)           out_valid <= 1'b1;
            else if (out_ready) out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/vec_fpint_cvt.sv
module vec_fpint_cvt
    import vec_fpint_cvt_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_op,
    input  logic [VW-1:0]    in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VW-1:0]    out_data,
    output logic [LANES-1:0] out_sat
);
    logic [VW-1:0]    conv_data;
    logic [LANES-1:0] conv_sat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cvt_lane u_lane (
            .op  (in_op),
            .src (in_data[g*LANE_W +: LANE_W]),
            .dst (conv_data[g*LANE_W +: LANE_W]),
            .sat (conv_sat[g])
        );
    end

    cvt_out_stage #(.DW(VW), .FW(LANES)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_data    (conv_data),
        .d_flag    (conv_sat),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q_data    (out_data),
        .q_flag    (out_sat)
    );
endmodule

// File: rtl/vec_fpint_cvt_chk.sv
module vec_fpint_cvt_chk #(
    parameter int LANES = 4,
    localparam int VW   = LANES * 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VW-1:0]    out_data,
    input logic [LANES-1:0] out_sat
);
    logic [1:0] held_op;

    always_ff @(posedge clk) begin
        if (rst)                      held_op <= 2'b00;
        else if (in_valid && in_ready) held_op <= in_op;
    end

    a_r11_reset_idle: assert property (@(posedge clk) rst |=> !out_valid && out_sat == '0);

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sat));

    a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    a_r10_int_src_no_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid && held_op[1] |-> out_sat == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_sat
        a_r3_signed_clamp_value: assert property (@(posedge clk) disable iff (rst)
            out_valid && held_op == 2'b00 && out_sat[g] |->
            (out_data[g*32 +: 32] == 32'h8000_0000 || out_data[g*32 +: 32] == 32'h7FFF_FFFF));
        a_r4_unsigned_clamp_value: assert property (@(posedge clk) disable iff (rst)
            out_valid && held_op == 2'b01 && out_sat[g] |->
            (out_data[g*32 +: 32] == 32'h0000_0000 || out_data[g*32 +: 32] == 32'hFFFF_FFFF));
    end
endmodule

bind vec_fpint_cvt vec_fpint_cvt_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sat   (out_sat)
);

// File: tb/vec_fpint_cvt_test.sv
`timescale 1ns/1ps
module vec_fpint_cvt_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [1:0]   in_op;
    logic [127:0] in_data;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_data;
    logic [3:0]   out_sat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vec_fpint_cvt uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sat(out_sat)
    );

    // {op, input lanes 3..0, expected lanes 3..0, expected flags 3..0}
    localparam int NV = 8;
    localparam logic [261:0] VEC [NV] = '{
        {2'b00, 128'hC02CCCCD_402CCCCD_BFC00000_3F800000, 128'hFFFFFFFE_00000002_FFFFFFFF_00000001, 4'b0000},
        {2'b00, 128'h4F000000_FF800000_7F800000_7FC00000, 128'h7FFFFFFF_80000000_7FFFFFFF_80000000, 4'b1111},
        {2'b00, 128'h42C98000_00000001_CF32D05E_CF000000, 128'h00000064_00000000_80000000_80000000, 4'b0010},
        {2'b01, 128'h4F7FFFFF_4F800000_BF800000_7FC00000, 128'hFFFFFF00_FFFFFFFF_00000000_00000000, 4'b0111},
        {2'b01, 128'h7F800000_BF000000_3F000000_4F000000, 128'hFFFFFFFF_00000000_00000000_80000000, 4'b1000},
        {2'b10, 128'h80000000_FFFFFFFF_00000001_00000000, 128'hCF000000_BF800000_3F800000_00000000, 4'b0000},
        {2'b10, 128'h00FFFFFF_00000064_01000001_7FFFFFFF, 128'h4B7FFFFF_42C80000_4B800000_4F000000, 4'b0000},
        {2'b11, 128'h00000001_01000003_80000000_FFFFFFFF, 128'h3F800000_4B800002_4F000000_4F800000, 4'b0000}
    };
    localparam string VTAG [NV] = '{
        "R1/R2/R8 trunc", "R5/R6/R3 specials", "R3/R2 signed edge",
        "R4/R5 unsigned clamp", "R4/R6/R10 unsigned mix",
        "R7 signed to float", "R7 rne ties", "R7/R8 unsigned to float"
    };

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_data = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(out_valid == 1'b0, "R11 out_valid", {127'd0, out_valid}, 128'd0);
        check(out_data == '0, "R11 out_data", out_data, 128'd0);
        check(out_sat == '0, "R11 out_sat", {124'd0, out_sat}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R11 idle after reset",
              {126'd0, in_ready, out_valid}, 128'd2);

        // table walk, consumer always ready
        for (int v = 0; v < NV; v++) begin
            in_valid = 1'b1;
            in_op    = VEC[v][261:260];
            in_data  = VEC[v][259:132];
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == 1'b1, {VTAG[v], " R9 valid"}, {127'd0, out_valid}, 128'd1);
            check(out_data == VEC[v][131:4], {VTAG[v], " data"}, out_data, VEC[v][131:4]);
            check(out_sat == VEC[v][3:0], {VTAG[v], " R10 flags"},
                  {124'd0, out_sat}, {124'd0, VEC[v][3:0]});
            @(negedge clk);
            check(out_valid == 1'b0, {VTAG[v], " R9 drains"}, {127'd0, out_valid}, 128'd0);
        end

        // R9: backpressure holds the result and blocks new input
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_op     = VEC[1][261:260];
        in_data   = VEC[1][259:132];
        @(negedge clk);
        in_op   = VEC[7][261:260];
        in_data = VEC[7][259:132];
        check(in_ready == 1'b0, "R9 ready low when full", {127'd0, in_ready}, 128'd0);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1, "R9 valid held", {127'd0, out_valid}, 128'd1);
        check(out_data == VEC[1][131:4], "R9 data held", out_data, VEC[1][131:4]);
        check(out_sat == 4'b1111, "R9 flags held", {124'd0, out_sat}, 128'hF);
        // release while a new input waits: replaced on the same edge
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9 back-to-back valid", {127'd0, out_valid}, 128'd1);
        check(out_data == VEC[7][131:4], "R9 back-to-back data", out_data, VEC[7][131:4]);
        check(out_sat == 4'b0000, "R10 flags clear for int source", {124'd0, out_sat}, 128'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 final drain", {127'd0, out_valid}, 128'd0);

        // R2: denormal and fractional lanes in signed mode, R1 lanes differ
        in_valid = 1'b1;
        in_op    = 2'b00;
        in_data  = 128'h80000001_BF7FFFFF_3F7FFFFF_007FFFFF;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_data == 128'd0 && out_sat == 4'd0, "R2 sub-one values give zero",
              out_data, 128'd0);

        // R11: reset mid-stream clears a held result
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = VEC[0][259:132];
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0 && out_data == '0, "R11 reset clears result",
              out_data, 128'd0);
        out_ready = 1'b1;
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule